// File: doc/BRIEF.md
# Sixteen-Pin Port Register Bank

This block is a memory-mapped bank of general-purpose pins that sits on a simple word-addressed register bus. For every pin it stores an output enable, an alternate-function select, a pull enable and a pull direction, together with the value driven when the pin is an output. The output-enable and alternate-function bits are changed through a pair of addresses: one address sets bits and the other clears them, and a bit written as zero leaves the pin alone. This lets separate software agents change separate pins without a read-modify-write sequence. Input pins pass through a synchronizer and can be read back. On a data read, pins that are driving return zero.

The block has two resets. The power-on reset `por_n` always returns every register to its default, including a retention flag. The warm reset `rst_n` either does the same or, when the retention flag is set, leaves the drive value, the output enables, the alternate functions and the pulls exactly as they were. A subsystem can therefore be reset without glitching the pins it owns. Read data is registered and is valid one cycle after the read request.

Top module: `pinbank_top`

## Requirements
- R1: After a power-on reset the output enables, drive values, pull enables and pull directions are all 0, the alternate-function bits equal the parameter `ALT_RESET`, the retention flag is 0 and the read data is 0.
- R2: A write to an enable-set address (output enable at byte address 0x010, alternate function at 0x018) sets each configuration bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to an enable-clear address (output enable at 0x014, alternate function at 0x01C) clears each configuration bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: A read of either the set address or the clear address of a pair returns the current configuration bits of that pair.
- R5: A read of address 0x000 returns, for each pin, the synchronized input when the output enable of that pin is 0, and 0 when it is 1. A change on an input pin becomes visible after two clock edges.
- R6: A read of address 0x004 returns the drive value ANDed with the output enable, pin by pin.
- R7: A write to 0x000 or 0x004 changes the drive value only on pins whose output enable is 1. The drive value of every other pin is unchanged.
- R8: A warm reset while the retention flag is 0 clears the drive values, output enables and pulls, and loads the alternate-function bits from `ALT_RESET`.
- R9: A warm reset while the retention flag is 1 leaves the drive values, output enables, alternate-function bits and pulls unchanged. The flag is bit 0 at 0x03C and only a power-on reset clears it. Bus writes made during a warm reset are ignored.
- R10: Bits 31:16 of every register read as 0, and writes to them have no effect. Bits 31:1 of the flag register read as 0.
- R11: Addresses outside the map read as 0, and writes to them change nothing.
- R12: Read data appears on the cycle after the read request. It is 0 on any cycle that follows a cycle with no read request or with a warm reset.
- R13: The pull-enable register at 0x040 and the pull-direction register at 0x044 are plain read/write registers. They drive `pin_pull_en` and `pin_pull_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| rst_n | input | 1 | Warm reset, active low, synchronous; honours the retention flag |
| bus_sel | input | 1 | Bus request valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Drive value per pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_alt | output | 16 | Alternate-function select per pin |
| pin_pull_en | output | 16 | Pull enable per pin |
| pin_pull_up | output | 16 | Pull direction per pin, 1 = up |

## Verification
The set and clear pairs are driven with overlapping patterns such as all ones, all zeros and sparse bits. This separates write-one behaviour from plain overwrites, and a data-word read shows whether the two addresses of a pair share one store. Data writes are made with a mix of enabled and disabled pins, so a leak into input pins shows up as a wrong pin value. Input patterns are applied under partial output enables to expose a missing read mask. Warm resets are issued with the flag both set and clear, and each is followed by random traffic that includes unmapped addresses and writes with upper bits set. This tells a dropped retention apart from a corrupted decode.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

   // Word offsets of the register map (byte addresses)
   localparam logic [11:0] OFS_DIN    = 12'h000;
   localparam logic [11:0] OFS_DOUT   = 12'h004;
   localparam logic [11:0] OFS_OE_SET = 12'h010;
   localparam logic [11:0] OFS_OE_CLR = 12'h014;
   localparam logic [11:0] OFS_AF_SET = 12'h018;
   localparam logic [11:0] OFS_AF_CLR = 12'h01C;
   localparam logic [11:0] OFS_KEEP   = 12'h03C;
   localparam logic [11:0] OFS_PEN    = 12'h040;
   localparam logic [11:0] OFS_PDIR   = 12'h044;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DIN,
      SEL_DOUT,
      SEL_OE_SET,
      SEL_OE_CLR,
      SEL_AF_SET,
      SEL_AF_CLR,
      SEL_KEEP,
      SEL_PEN,
      SEL_PDIR
   } reg_sel_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pinbank_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk) begin
      if (!por_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pinbank_setclr.sv
module pinbank_setclr #(
   parameter int           N       = 16,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         warm_n,
   input  logic         keep,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [N-1:0] bits,
   output logic [N-1:0] q
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!por_n)                    q[i] <= RST_VAL[i];
         else if (!warm_n && !keep)     q[i] <= RST_VAL[i];
         else if (!warm_n)              q[i] <= q[i];
         else if (set_we && bits[i])    q[i] <= 1'b1;
         else if (clr_we && bits[i])    q[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/pinbank_field.sv
module pinbank_field #(
   parameter int           N       = 16,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         warm_n,
   input  logic         keep,
   input  logic [N-1:0] we_bits,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!por_n)                q[i] <= RST_VAL[i];
         else if (!warm_n && !keep) q[i] <= RST_VAL[i];
         else if (!warm_n)          q[i] <= q[i];
         else if (we_bits[i])       q[i] <= d[i];
      end
   end

endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
   import pinbank_pkg::*;
#(
   parameter int           N           = 16,
   parameter int           ADDR_W      = 12,
   parameter int           DATA_W      = 32,
   parameter int           SYNC_STAGES = 2,
   parameter logic [N-1:0] ALT_RESET   = '0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N-1:0]      pin_in,
   output logic [N-1:0]      pin_out,
   output logic [N-1:0]      pin_oe,
   output logic [N-1:0]      pin_alt,
   output logic [N-1:0]      pin_pull_en,
   output logic [N-1:0]      pin_pull_up
);

   localparam int PAD_W = DATA_W - N;

   if (N < 1 || N > DATA_W - 1) begin : g_bad_n
      $error("pinbank_top: N must lie in 1..DATA_W-1");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("pinbank_top: ADDR_W must cover the 12-bit map");
   end

   reg_sel_e          rsel;
   logic              wr_en;
   logic              rd_en;
   logic [N-1:0]      wbits;
   logic [N-1:0]      oe_q;
   logic [N-1:0]      af_q;
   logic [N-1:0]      out_q;
   logic [N-1:0]      pen_q;
   logic [N-1:0]      pdir_q;
   logic [N-1:0]      in_s;
   logic [N-1:0]      out_we;
   logic              soft_q;
   logic [DATA_W-1:0] rd_val;

   // address decode
   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_DIN):    rsel = SEL_DIN;
         ADDR_W'(OFS_DOUT):   rsel = SEL_DOUT;
         ADDR_W'(OFS_OE_SET): rsel = SEL_OE_SET;
         ADDR_W'(OFS_OE_CLR): rsel = SEL_OE_CLR;
         ADDR_W'(OFS_AF_SET): rsel = SEL_AF_SET;
         ADDR_W'(OFS_AF_CLR): rsel = SEL_AF_CLR;
         ADDR_W'(OFS_KEEP):   rsel = SEL_KEEP;
         ADDR_W'(OFS_PEN):    rsel = SEL_PEN;
         ADDR_W'(OFS_PDIR):   rsel = SEL_PDIR;
         default:             rsel = SEL_NONE;
      endcase
   end

   assign wr_en = bus_sel && bus_wr && rst_n;
   assign rd_en = bus_sel && !bus_wr;
   assign wbits = bus_wdata[N-1:0];

   // pin input synchronizer
   pinbank_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .por_n (por_n),
      .d     (pin_in),
      .q     (in_s)
   );

   // set/clear configuration banks
   pinbank_setclr #(.N(N), .RST_VAL('0)) u_oe (
      .clk    (clk),
      .por_n  (por_n),
      .warm_n (rst_n),
      .keep   (soft_q),
      .set_we (wr_en && rsel == SEL_OE_SET),
      .clr_we (wr_en && rsel == SEL_OE_CLR),
      .bits   (wbits),
      .q      (oe_q)
   );

   pinbank_setclr #(.N(N), .RST_VAL(ALT_RESET)) u_af (
      .clk    (clk),
      .por_n  (por_n),
      .warm_n (rst_n),
      .keep   (soft_q),
      .set_we (wr_en && rsel == SEL_AF_SET),
      .clr_we (wr_en && rsel == SEL_AF_CLR),
      .bits   (wbits),
      .q      (af_q)
   );

   // drive value: only enabled pins take the write
   assign out_we = (wr_en && (rsel == SEL_DIN || rsel == SEL_DOUT)) ? oe_q : '0;

   pinbank_field #(.N(N), .RST_VAL('0)) u_out (
      .clk     (clk),
      .por_n   (por_n),
      .warm_n  (rst_n),
      .keep    (soft_q),
      .we_bits (out_we),
      .d       (wbits),
      .q       (out_q)
   );

   pinbank_field #(.N(N), .RST_VAL('0)) u_pen (
      .clk     (clk),
      .por_n   (por_n),
      .warm_n  (rst_n),
      .keep    (soft_q),
      .we_bits ({N{wr_en && rsel == SEL_PEN}}),
      .d       (wbits),
      .q       (pen_q)
   );

   pinbank_field #(.N(N), .RST_VAL('0)) u_pdir (
      .clk     (clk),
      .por_n   (por_n),
      .warm_n  (rst_n),
      .keep    (soft_q),
      .we_bits ({N{wr_en && rsel == SEL_PDIR}}),
      .d       (wbits),
      .q       (pdir_q)
   );

   // retention flag, cleared only by power-on reset
   always_ff @(posedge clk) begin
      if (!por_n)                         soft_q <= 1'b0;
      else if (wr_en && rsel == SEL_KEEP) soft_q <= bus_wdata[0];
   end

   // read mux
   always_comb begin
      rd_val = '0;
      case (rsel)
         SEL_DIN:                rd_val = {{PAD_W{1'b0}}, in_s & ~oe_q};
         SEL_DOUT:               rd_val = {{PAD_W{1'b0}}, out_q & oe_q};
         SEL_OE_SET, SEL_OE_CLR: rd_val = {{PAD_W{1'b0}}, oe_q};
         SEL_AF_SET, SEL_AF_CLR: rd_val = {{PAD_W{1'b0}}, af_q};
         SEL_KEEP:               rd_val = {{(DATA_W-1){1'b0}}, soft_q};
         SEL_PEN:                rd_val = {{PAD_W{1'b0}}, pen_q};
         SEL_PDIR:               rd_val = {{PAD_W{1'b0}}, pdir_q};
         default:                rd_val = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!por_n || !rst_n) bus_rdata <= '0;
      else if (rd_en)       bus_rdata <= rd_val;
      else                  bus_rdata <= '0;
   end

   assign pin_out     = out_q;
   assign pin_oe      = oe_q;
   assign pin_alt     = af_q;
   assign pin_pull_en = pen_q;
   assign pin_pull_up = pdir_q;

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
   parameter int           N         = 16,
   parameter int           ADDR_W    = 12,
   parameter int           DATA_W    = 32,
   parameter logic [N-1:0] ALT_RESET = '0
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [N-1:0]      pin_out,
   input logic [N-1:0]      pin_oe,
   input logic [N-1:0]      pin_alt,
   input logic              soft_q
);

   logic wr_ok;
   assign wr_ok = bus_sel && bus_wr && rst_n;

   assert_oe_set_R2: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ok && bus_addr == ADDR_W'(12'h010))
      |=> pin_oe == ($past(pin_oe) | $past(bus_wdata[N-1:0])));

   assert_oe_clear_R3: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ok && bus_addr == ADDR_W'(12'h014))
      |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata[N-1:0])));

   assert_input_pins_kept_R7: assert property (@(posedge clk) disable iff (!por_n)
      (wr_ok && (bus_addr == ADDR_W'(12'h000) || bus_addr == ADDR_W'(12'h004)))
      |=> ((pin_out ^ $past(pin_out)) & ~$past(pin_oe)) == '0);

   assert_cold_warm_R8: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n && !soft_q)
      |=> (pin_oe == '0 && pin_out == '0 && pin_alt == ALT_RESET));

   assert_retain_R9: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n && soft_q)
      |=> (pin_oe == $past(pin_oe) && pin_out == $past(pin_out)
           && pin_alt == $past(pin_alt)));

   assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!por_n)
      bus_rdata[DATA_W-1:N] == '0);

   assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!por_n)
      (!(bus_sel && !bus_wr) || !rst_n) |=> bus_rdata == '0);

endmodule

bind pinbank_top pinbank_chk #(
   .N         (N),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .ALT_RESET (ALT_RESET)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .pin_alt   (pin_alt),
   .soft_q    (soft_q)
);

// File: tb/sim_pinbank_top.sv
module sim_pinbank_top;

   localparam int          N   = 16;
   localparam int          AW  = 12;
   localparam int          DW  = 32;
   localparam logic [15:0] ALT = 16'h3C05;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          rst_n = 1'b1;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe, pin_alt, pin_pull_en, pin_pull_up;

   int n_chk = 0;
   int n_bad = 0;

   // bench model
   logic [15:0] m_oe, m_af, m_out, m_pen, m_pdir;
   logic        m_keep;

   always #5 clk = ~clk;

   pinbank_top #(.N(N), .ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .ALT_RESET(ALT)) u0 (
      .clk         (clk),
      .por_n       (por_n),
      .rst_n       (rst_n),
      .bus_sel     (bus_sel),
      .bus_wr      (bus_wr),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .pin_in      (pin_in),
      .pin_out     (pin_out),
      .pin_oe      (pin_oe),
      .pin_alt     (pin_alt),
      .pin_pull_en (pin_pull_en),
      .pin_pull_up (pin_pull_up)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void mdl_write(input logic [11:0] a, input logic [31:0] d);
      case (a)
         12'h000, 12'h004: m_out = (m_out & ~m_oe) | (d[15:0] & m_oe);
         12'h010: m_oe   = m_oe | d[15:0];
         12'h014: m_oe   = m_oe & ~d[15:0];
         12'h018: m_af   = m_af | d[15:0];
         12'h01C: m_af   = m_af & ~d[15:0];
         12'h03C: m_keep = d[0];
         12'h040: m_pen  = d[15:0];
         12'h044: m_pdir = d[15:0];
         default: ;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         12'h000:          return {16'h0, pin_in & ~m_oe};
         12'h004:          return {16'h0, m_out & m_oe};
         12'h010, 12'h014: return {16'h0, m_oe};
         12'h018, 12'h01C: return {16'h0, m_af};
         12'h03C:          return {31'h0, m_keep};
         12'h040:          return {16'h0, m_pen};
         12'h044:          return {16'h0, m_pdir};
         default:          return 32'h0;
      endcase
   endfunction

   function automatic logic [11:0] pick_addr(input int k);
      case (k)
         0: return 12'h000;  1: return 12'h004;  2: return 12'h010;
         3: return 12'h014;  4: return 12'h018;  5: return 12'h01C;
         6: return 12'h03C;  7: return 12'h040;  8: return 12'h044;
         9: return 12'h008; 10: return 12'h048; default: return 12'h400;
      endcase
   endfunction

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      mdl_write(a, d);
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic read_check(input string tag, input logic [11:0] a);
      logic [31:0] v;
      bus_read(a, v);
      check(tag, v, exp_read(a));
   endtask

   task automatic pins_check(input string tag);
      check({tag, " pin_out"}, {16'h0, pin_out}, {16'h0, m_out});
      check({tag, " pin_oe"},  {16'h0, pin_oe},  {16'h0, m_oe});
      check({tag, " pin_alt"}, {16'h0, pin_alt}, {16'h0, m_af});
      check({tag, " pulls"},   {pin_pull_en, pin_pull_up}, {m_pen, m_pdir});
   endtask

   task automatic warm_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      if (!m_keep) begin
         m_out = '0; m_oe = '0; m_af = ALT; m_pen = '0; m_pdir = '0;
      end
   endtask

   task automatic set_pins(input logic [15:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5EED_0042));
      m_oe = '0; m_af = ALT; m_out = '0; m_pen = '0; m_pdir = '0; m_keep = 1'b0;
      repeat (4) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      pins_check("R1");
      check("R1 rdata", bus_rdata, 32'h0);
      read_check("R1 keep flag", 12'h03C);

      // R2 / R4 set addresses
      bus_write(12'h010, 32'h0000_00FF);
      read_check("R2 oe set", 12'h010);
      read_check("R4 oe via clear addr", 12'h014);
      bus_write(12'h010, 32'h0000_0000);
      read_check("R2 zero write no effect", 12'h010);
      bus_write(12'h018, 32'h0000_8000);
      read_check("R4 af via set addr", 12'h018);
      read_check("R4 af via clear addr", 12'h01C);

      // R3 clear addresses
      bus_write(12'h014, 32'h0000_000F);
      read_check("R3 oe clear", 12'h010);
      bus_write(12'h01C, 32'h0000_0004);
      read_check("R3 af clear", 12'h01C);
      bus_write(12'h014, 32'h0);
      pins_check("R3 zero clear no effect");

      // R10 upper bits
      bus_write(12'h010, 32'hFFFF_0100);
      read_check("R10 upper ignored", 12'h010);
      bus_write(12'h03C, 32'hFFFF_FFFE);
      read_check("R10 keep upper zero", 12'h03C);

      // R7 / R6 data writes
      bus_write(12'h000, 32'h0000_FFFF);
      check("R7 only enabled pins", {16'h0, pin_out}, {16'h0, m_out});
      bus_write(12'h004, 32'h0000_0050);
      check("R7 via dout addr", {16'h0, pin_out}, {16'h0, m_out});
      read_check("R6 dout readback", 12'h004);

      // R5 input mask
      set_pins(16'h1234);
      read_check("R5 din masked", 12'h000);
      set_pins(16'hFFFF);
      read_check("R5 din all ones", 12'h000);

      // R11 unmapped
      bus_write(12'h008, 32'hFFFF_FFFF);
      bus_write(12'h048, 32'hFFFF_FFFF);
      bus_write(12'h400, 32'hFFFF_FFFF);
      read_check("R11 unmapped read", 12'h048);
      pins_check("R11 unmapped no effect");

      // R12 read latency and idle zero
      bus_read(12'h010, v);
      check("R12 one-cycle read", v, exp_read(12'h010));
      @(negedge clk);
      check("R12 idle zero", bus_rdata, 32'h0);

      // R13 pulls
      bus_write(12'h040, 32'h0000_A5A5);
      bus_write(12'h044, 32'h0000_0F0F);
      pins_check("R13 pulls");
      read_check("R13 pen read", 12'h040);
      read_check("R13 pdir read", 12'h044);

      // R9 retention
      bus_write(12'h03C, 32'h1);
      warm_reset();
      pins_check("R9 retained");
      read_check("R9 flag survives", 12'h03C);

      // R8 full warm reset
      bus_write(12'h03C, 32'h0);
      warm_reset();
      pins_check("R8 cleared");

      // random traffic
      for (int it = 0; it < 400; it++) begin
         int op = $urandom_range(0, 19);
         logic [11:0] a = pick_addr($urandom_range(0, 11));
         logic [31:0] d = $urandom();
         if (op < 9) begin
            bus_write(a, d);
            pins_check("R2 R3 R7 random write");
         end else if (op < 17) begin
            read_check("R4 R5 R6 R11 random read", a);
         end else if (op < 19) begin
            set_pins(16'($urandom()));
            read_check("R5 random pins", 12'h000);
         end else begin
            warm_reset();
            pins_check("R8 R9 random reset");
         end
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule